// File: doc/BRIEF.md
# Block Cipher DMA Engine Register Bank

This block is the software-visible register bank that sits in front of a block-cipher DMA datapath. A simple 32-bit bus port with valid and ready signals reaches five word registers: a control and status word, a source address, a destination address, a 128-bit key and a 128-bit initial chaining value. The key and the chaining value are each written as four successive 32-bit words to a single address. The bank assembles them and presents the full 128-bit values to the datapath.

The control word holds the fields the datapath needs to run a transfer: cipher enable, decrypt select, a flag to continue from the previous run's chaining value, and a block count stored as the number of 16-byte blocks minus one. Writing the control word with its top bit set produces a single-cycle start pulse and marks the engine busy. The datapath reports completion and faults back. The bank then clears busy, latches a completion flag and an error flag, and drives an interrupt when the interrupt enable is set. Writing zero to the control word always returns the engine to idle.

Top module: `cipher_regbank`

## Requirements
- R1: Word offsets decode as control 0x00, source 0x04, destination 0x08, key 0x0C, IV 0x10. Source and destination read back as written. Reads of key, IV or any unmapped offset return 0. Read data is valid on `rd_valid` one cycle after the read request.
- R2: Four writes to 0x0C fill the key most significant word first. After the writes, `dp_key[127:96]` holds the first word and `dp_key[31:0]` holds the fourth. Each word is taken unchanged as a big-endian value.
- R3: Four writes to 0x10 fill `dp_iv` in the same order. The IV word counter is separate from the key word counter.
- R4: Each 128-bit register's word counter wraps after the fourth write, so a fifth write replaces the most significant word again.
- R5: A control write with bit 31 set, accepted while idle, raises `dp_start` for exactly one cycle and sets busy. Control bit 31 reads 1 while busy.
- R6: An accepted control write stores bit 30 (interrupt enable), bit 28 (cipher enable, `dp_cipher_en`), bit 27 (decrypt, `dp_decrypt`), bit 12 (chain, `dp_chain`) and bits 11:0 (blocks minus one, `dp_blocks_m1`). Control reads return these fields at the same bit positions. Bits 26:13 read 0.
- R7: While busy, a nonzero control write has no effect on any field, on busy, or on the start pulse.
- R8: A control write of zero, in any state, clears busy, every control field, the completion and error flags, and both word counters.
- R9: `dp_done` while busy clears busy, so bit 31 reads 0, and sets the completion flag. `dp_fault` while busy sets the error flag, which reads as control bit 29. Control writes cannot set bit 29. Any accepted control write clears both flags.
- R10: `irq` is high exactly when the completion flag and the interrupt enable are both set. A control write clears it.
- R11: After reset, all registers, outputs and flags are zero, and `bus_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Bank accepts the access (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| dp_start | output | 1 | One-cycle start pulse to the datapath |
| dp_busy | output | 1 | Operation in progress |
| dp_src | output | 32 | Source address |
| dp_dst | output | 32 | Destination address |
| dp_key | output | 128 | Assembled key |
| dp_iv | output | 128 | Assembled initial chaining value |
| dp_cipher_en | output | 1 | Cipher enable (0 = plain copy) |
| dp_decrypt | output | 1 | Decrypt select |
| dp_chain | output | 1 | Continue from the previous chaining value |
| dp_blocks_m1 | output | 12 | Block count minus one |
| dp_done | input | 1 | Datapath completion pulse |
| dp_fault | input | 1 | Datapath error pulse |
| irq | output | 1 | Completion interrupt |

## Verification
The key and IV loaders are driven with random word sequences of random length, interleaved with each other and with address writes. The bench's word-pointer model tells apart correct per-register counters, shared counters and counters that wrap wrongly. Control-word patterns are applied while idle and while busy: start with fields set, nonzero writes during an operation, zero writes mid-load and mid-operation, and completion with and without a fault. These patterns separate the ignore-while-busy rule from the always-honoured reset write. Completion is run with the interrupt enable both on and off, to show that the interrupt depends on the enable bit and not on completion alone.

// File: rtl/cipher_regbank_pkg.sv
package cipher_regbank_pkg;
  localparam int DATA_W = 32;
  localparam int OFFS_W = 5;
  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_SRC  = 3'd1,
    IDX_DST  = 3'd2,
    IDX_KEY  = 3'd3,
    IDX_IV   = 3'd4
  } reg_idx_e;
  localparam int BIT_GO    = 31;
  localparam int BIT_IRQEN = 30;
  localparam int BIT_ERR   = 29;
  localparam int BIT_ENA   = 28;
  localparam int BIT_DEC   = 27;
endpackage

// File: rtl/cipher_regbank_wide.sv
module cipher_regbank_wide #(
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_ptr,
  input  logic                wr_en,
  input  logic [DW-1:0]       wdata,
  output logic [DW*WORDS-1:0] value
);
  localparam int PW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [PW-1:0] LAST = PW'(WORDS - 1);

  logic [PW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst || clr_ptr) ptr <= '0;
    else if (wr_en)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // word 0 is the most significant slice
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                              word_q <= '0;
      else if (wr_en && ptr == PW'(g))      word_q <= wdata;
    end
    assign value[DW*(WORDS-g)-1 -: DW] = word_q;
  end
endmodule

// File: rtl/cipher_regbank_ctrl.sv
module cipher_regbank_ctrl
  import cipher_regbank_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done_in,
  input  logic              fault_in,
  output logic              start,
  output logic              busy,
  output logic              cipher_en,
  output logic              decrypt,
  output logic              chain,
  output logic [CNT_W-1:0]  blocks_m1,
  output logic              irq,
  output logic              zero_wr,
  output logic [DATA_W-1:0] word
);
  localparam int PAD_W = BIT_DEC - CNT_W - 1;

  logic irq_en, err_q, done_q;

  assign zero_wr = wr_en && (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst || zero_wr) begin
      start <= 1'b0; busy <= 1'b0; irq_en <= 1'b0; err_q <= 1'b0;
      done_q <= 1'b0; cipher_en <= 1'b0; decrypt <= 1'b0;
      chain <= 1'b0; blocks_m1 <= '0;
    end else begin
      start <= 1'b0;
      if (busy && done_in) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
      end
      if (busy && fault_in) err_q <= 1'b1;
      if (wr_en && !busy) begin
        irq_en    <= wdata[BIT_IRQEN];
        cipher_en <= wdata[BIT_ENA];
        decrypt   <= wdata[BIT_DEC];
        chain     <= wdata[CNT_W];
        blocks_m1 <= wdata[CNT_W-1:0];
        done_q    <= 1'b0;
        err_q     <= 1'b0;
        if (wdata[BIT_GO]) begin
          busy  <= 1'b1;
          start <= 1'b1;
        end
      end
    end
  end

  assign irq  = done_q && irq_en;
  assign word = {busy, irq_en, err_q, cipher_en, decrypt, {PAD_W{1'b0}}, chain, blocks_m1};
endmodule

// File: rtl/cipher_regbank.sv
module cipher_regbank
  import cipher_regbank_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int WIDE_W   = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  output logic               bus_ready,
  input  logic               bus_write,
  input  logic [OFFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               dp_start,
  output logic               dp_busy,
  output logic [DATA_W-1:0]  dp_src,
  output logic [DATA_W-1:0]  dp_dst,
  output logic [WIDE_W-1:0]  dp_key,
  output logic [WIDE_W-1:0]  dp_iv,
  output logic               dp_cipher_en,
  output logic               dp_decrypt,
  output logic               dp_chain,
  output logic [CNT_W-1:0]   dp_blocks_m1,
  input  logic               dp_done,
  input  logic               dp_fault,
  output logic               irq
);
  localparam int WORDS = WIDE_W / DATA_W;

  logic [2:0]        idx;
  logic              wr, rd, hit;
  logic              wr_ctrl, wr_src, wr_dst, wr_key, wr_iv;
  logic              zero_wr;
  logic [DATA_W-1:0] ctrl_word;

  assign bus_ready = 1'b1;
  assign idx  = bus_addr[OFFS_W-1:2];
  assign hit  = (bus_addr[1:0] == 2'b00);
  assign wr   = bus_valid && bus_write && hit;
  assign rd   = bus_valid && !bus_write;

  assign wr_ctrl = wr && idx == IDX_CTRL;
  assign wr_src  = wr && idx == IDX_SRC;
  assign wr_dst  = wr && idx == IDX_DST;
  assign wr_key  = wr && idx == IDX_KEY;
  assign wr_iv   = wr && idx == IDX_IV;

  cipher_regbank_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_ctrl), .wdata(bus_wdata),
    .done_in(dp_done), .fault_in(dp_fault), .start(dp_start),
    .busy(dp_busy), .cipher_en(dp_cipher_en), .decrypt(dp_decrypt),
    .chain(dp_chain), .blocks_m1(dp_blocks_m1), .irq(irq),
    .zero_wr(zero_wr), .word(ctrl_word)
  );

  cipher_regbank_wide #(.DW(DATA_W), .WORDS(WORDS)) u_key (
    .clk(clk), .rst(rst), .clr_ptr(zero_wr), .wr_en(wr_key),
    .wdata(bus_wdata), .value(dp_key)
  );

  cipher_regbank_wide #(.DW(DATA_W), .WORDS(WORDS)) u_iv (
    .clk(clk), .rst(rst), .clr_ptr(zero_wr), .wr_en(wr_iv),
    .wdata(bus_wdata), .value(dp_iv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_src <= '0;
      dp_dst <= '0;
    end else begin
      if (wr_src) dp_src <= bus_wdata;
      if (wr_dst) dp_dst <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        if (!hit)                rd_data <= '0;
        else if (idx == IDX_CTRL) rd_data <= ctrl_word;
        else if (idx == IDX_SRC)  rd_data <= dp_src;
        else if (idx == IDX_DST)  rd_data <= dp_dst;
        else                      rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/cipher_regbank_chk.sv
module cipher_regbank_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [4:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             rd_valid,
  input logic             dp_start,
  input logic             dp_busy,
  input logic [CNT_W-1:0] dp_blocks_m1,
  input logic             dp_done,
  input logic             irq
);
  logic ctrl_wr;
  assign ctrl_wr = bus_valid && bus_write && bus_addr == 5'h00;

  a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
    dp_start |=> !dp_start);
  a_r5_start_busy: assert property (@(posedge clk) disable iff (rst)
    dp_start |-> dp_busy);
  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && dp_busy && bus_wdata != 32'h0 && !dp_done)
      |=> (dp_busy && !dp_start && $stable(dp_blocks_m1)));
  a_r8_zero_idle: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata == 32'h0) |=> (!dp_busy && !irq && dp_blocks_m1 == '0));
  a_r9_done_ends: assert property (@(posedge clk) disable iff (rst)
    (dp_busy && dp_done && !ctrl_wr) |=> !dp_busy);
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(dp_done));
  a_r10_irq_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !dp_busy) |=> !irq);
  a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_valid && !bus_write));
endmodule

bind cipher_regbank cipher_regbank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .dp_start(dp_start), .dp_busy(dp_busy), .dp_blocks_m1(dp_blocks_m1),
  .dp_done(dp_done), .irq(irq)
);

// File: tb/cipher_regbank_bench.sv
module cipher_regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 0, bus_write = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_ready, rd_valid, dp_start, dp_busy, dp_cipher_en, dp_decrypt, dp_chain, irq;
  logic [31:0] rd_data, dp_src, dp_dst;
  logic [127:0] dp_key, dp_iv;
  logic [11:0] dp_blocks_m1;
  logic dp_done = 0, dp_fault = 0;

  int checks = 0, fails = 0;
  logic [127:0] m_key, m_iv;
  int kp, ip;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_regbank u_cipher_regbank (.*);

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [127:0] put_word(logic [127:0] v, int p, logic [31:0] w);
    logic [127:0] r = v;
    r[127 - 32*p -: 32] = w;
    return r;
  endfunction

  function automatic logic [31:0] ctrl_exp(logic go, logic ie, logic er, logic en,
                                           logic de, logic ch, logic [11:0] n);
    return {go, ie, er, en, de, 14'b0, ch, n};
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    if (a == 5'h0C) begin m_key = put_word(m_key, kp, d); kp = (kp + 1) % 4; end
    if (a == 5'h10) begin m_iv  = put_word(m_iv,  ip, d); ip = (ip + 1) % 4; end
    if (a == 5'h00 && d == 0) begin kp = 0; ip = 0; end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    checks++;
    if (rd_valid !== 1'b1) begin fails++; $display("FAIL R1 rd_valid actual=%b expected=1", rd_valid); end
    d = rd_data;
  endtask

  task automatic pulse_done(logic flt);
    @(negedge clk);
    dp_done = 1; dp_fault = flt;
    @(negedge clk);
    dp_done = 0; dp_fault = 0;
  endtask

  initial begin
    logic [31:0] r, w;
    void'($urandom(32'h5eed));
    m_key = 0; m_iv = 0; kp = 0; ip = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 busy/start/irq", {dp_busy, dp_start, irq, bus_ready}, 4'b0001);
    chk("R11 key", dp_key, 0);
    rd(5'h00, r); chk("R11 ctrl read", r, 0);

    // R1 decode
    wr(5'h04, 32'h1234_5670); wr(5'h08, 32'hCAFE_0010);
    rd(5'h04, r); chk("R1 src readback", r, 32'h1234_5670);
    rd(5'h08, r); chk("R1 dst readback", r, 32'hCAFE_0010);
    chk("R1 dp_src", dp_src, 32'h1234_5670);
    rd(5'h14, r); chk("R1 unmapped read", r, 0);

    // R2 key order, R3 IV order, interleaved
    wr(5'h0C, 32'h0001_0203); wr(5'h10, 32'hA0A1_A2A3);
    wr(5'h0C, 32'h0405_0607); wr(5'h0C, 32'h0809_0A0B); wr(5'h0C, 32'h0C0D_0E0F);
    chk("R2 key MSW first", dp_key, 128'h00010203_04050607_08090A0B_0C0D0E0F);
    rd(5'h0C, r); chk("R1 key read zero", r, 0);
    wr(5'h10, 32'hB0B1_B2B3); wr(5'h10, 32'hC0C1_C2C3); wr(5'h10, 32'hD0D1_D2D3);
    chk("R3 iv order", dp_iv, 128'hA0A1A2A3_B0B1B2B3_C0C1C2C3_D0D1D2D3);
    // R4 wrap
    wr(5'h0C, 32'hFFFF_0000);
    chk("R4 wrap to MSW", dp_key, 128'hFFFF0000_04050607_08090A0B_0C0D0E0F);

    // random key/iv/address traffic
    for (int i = 0; i < 60; i++) begin
      w = $urandom;
      case ($urandom % 4)
        0: begin wr(5'h0C, w); chk("R2 random key", dp_key, m_key); end
        1: begin wr(5'h10, w); chk("R3 random iv", dp_iv, m_iv); end
        2: begin wr(5'h04, w); rd(5'h04, r); chk("R1 random src", r, w); end
        default: begin wr(5'h08, w); chk("R1 random dst", dp_dst, w); end
      endcase
    end

    // R8 zero write resets counters mid-load
    wr(5'h0C, 32'h1111_1111); wr(5'h00, 0);
    for (int i = 0; i < 4; i++) wr(5'h0C, 32'h2000_0000 + i);
    chk("R8 counter reset", dp_key, 128'h20000000_20000001_20000002_20000003);

    // R5/R6 start with fields
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 0; bus_wdata = 32'hD800_1005;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    chk("R5 start pulse", {dp_start, dp_busy}, 2'b11);
    @(negedge clk);
    chk("R5 start one cycle", {dp_start, dp_busy}, 2'b01);
    chk("R6 fields", {dp_cipher_en, dp_decrypt, dp_chain, dp_blocks_m1}, {3'b111, 12'h005});
    rd(5'h00, r); chk("R6 ctrl readback busy", r, ctrl_exp(1,1,0,1,1,1,12'h005));
    // R7 ignored while busy
    wr(5'h00, 32'h9000_0FFF);
    chk("R7 no restart", {dp_start, dp_busy, dp_blocks_m1}, {2'b01, 12'h005});
    rd(5'h00, r); chk("R7 ctrl unchanged", r, ctrl_exp(1,1,0,1,1,1,12'h005));
    // R9/R10 completion with irq enabled
    pulse_done(0);
    chk("R9 busy cleared", dp_busy, 0);
    chk("R10 irq on done", irq, 1);
    rd(5'h00, r); chk("R9 bit31 reads 0", r, ctrl_exp(0,1,0,1,1,1,12'h005));
    wr(5'h00, 32'h4000_0000);
    chk("R10 irq cleared by write", irq, 0);

    // R9 fault, irq disabled
    wr(5'h00, 32'h9000_0002);
    pulse_done(1);
    chk("R10 irq disabled", irq, 0);
    rd(5'h00, r); chk("R9 error bit", r, ctrl_exp(0,0,1,1,0,0,12'h002));
    wr(5'h00, 32'h2000_0000);
    rd(5'h00, r); chk("R9 error not settable, cleared", r, 0);

    // R8 zero write while busy
    wr(5'h00, 32'hC000_0007);
    wr(5'h00, 0);
    chk("R8 idle after zero", {dp_busy, irq, dp_blocks_m1}, 14'h0);
    pulse_done(0);
    chk("R8 late done ignored", irq, 0);
    rd(5'h00, r); chk("R8 ctrl zero", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule